// File: doc/BRIEF.md
# Shared Peripheral Interrupt Group Aggregator

This block gathers many peripheral interrupt sources (timer modules, the serial interface, an external peripheral line, low-voltage detection and EEPROM write completion) into a small number of shared interrupt groups. Each source has a sticky flag, set by a one-cycle strobe from its peripheral, and an enable of its own. A fixed parameter table assigns each source to one group. When an enabled source's flag goes from clear to set, the group flag for that source's group is raised.

The block offers the interrupt controller one request, and the index of the winning group, whenever an enabled group flag is pending, the global enable is on and the call stack has room. When the controller acknowledges service, only the winning group's flag and the global enable are dropped. The source flags stay set until software writes them clear through the register port. This is how software finds which member of the group fired.

Top module: `mfi_aggregator`

## Requirements
- R1: After reset every source flag, source enable, group flag, group enable and the global enable read as 0, and `irqReq` is low.
- R2: A high `srcSet[i]` sets source flag i on the next clock edge whether or not that source is enabled. Source flags read back at address 0, with bit i holding source i.
- R3: When an enabled source's flag rises, the flag of that source's group is set on the same edge. With the default map, source i belongs to group i/2. Group flags read at address 2, with bit g holding group g.
- R4: A strobe from a source whose enable (address 1, bit i) is 0 does not set any group flag.
- R5: A strobe on a source whose flag is already set is not a rising event, and it does not set the group flag.
- R6: `irqReq` is high exactly when the global enable (address 4, bit 0) is 1, `stackNotFull` is 1, and some group has both its flag and its enable (address 3, bit g) set.
- R7: When several enabled groups are pending, `irqGrp` gives the lowest-numbered one.
- R8: An `ackIn` pulse while `irqReq` is high clears the flag of the group shown on `irqGrp` and the global enable on the next edge. All source flags stay as they were.
- R9: Writing address 0 or 2 clears each flag whose data bit is 0 and keeps each flag whose data bit is 1. A hardware set on the same cycle wins over the clear.
- R10: Enable registers read back what was written, and an `ackIn` pulse while `irqReq` is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcSet | input | NUM_SRC | One-cycle set strobes from the peripherals, one per source |
| stackNotFull | input | 1 | High when the call stack can accept another entry |
| ackIn | input | 1 | Service acknowledge from the interrupt controller |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | DW | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | DW | Register read data, combinational |
| irqReq | output | 1 | Group interrupt request to the controller |
| irqGrp | output | GW | Index of the requesting group |

## Verification
Single-source strobes are applied to an enabled member, to a disabled member and to a member whose flag is already set. These cases separate edge-triggered group setting from level-triggered setting, and show whether the member enable is honoured. Strobes are then added to higher- and lower-numbered groups one at a time, which shows whether the priority is fixed or follows arrival order. An acknowledge is applied with a request pending and then with none pending, which tells group-flag clearing apart from source-flag clearing. A software clear is written on the same cycle as a hardware set, which shows which of the two wins.

// File: rtl/mfi_pkg.sv
package mfi_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_SRC_FLAG = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_SRC_EN   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_GRP_FLAG = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_GRP_EN   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CTL      = 3'd4;
  localparam int MAP_W = 3;

  typedef struct packed {
    logic wrSrcFlag;
    logic wrSrcEn;
    logic wrGrpFlag;
    logic wrGrpEn;
    logic wrCtl;
    logic service;
  } mfiStrobe_t;
endpackage

// File: rtl/mfi_ctrl.sv
module mfi_ctrl
  import mfi_pkg::*;
#(
  parameter int NUM_GRP = 4,
  parameter int GW = 2
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [NUM_GRP-1:0] grpFlag,
  input  logic [NUM_GRP-1:0] grpEn,
  input  logic              globalEn,
  input  logic              stackNotFull,
  input  logic              ackIn,
  output mfiStrobe_t        stb,
  output logic [GW-1:0]     svcGrp,
  output logic              irqReq,
  output logic [GW-1:0]     irqGrp
);
  logic [NUM_GRP-1:0] pending;
  logic [GW-1:0] winner;

  assign pending = grpFlag & grpEn;

  // fixed priority: the lowest index wins
  always_comb begin
    winner = '0;
    for (int g = NUM_GRP - 1; g >= 0; g--) begin
      if (pending[g]) winner = GW'(g);
    end
  end

  assign irqReq = globalEn && stackNotFull && (|pending);
  assign irqGrp = winner;
  assign svcGrp = winner;

  always_comb begin
    stb.wrSrcFlag = wrEn && (wrAddr == ADDR_SRC_FLAG);
    stb.wrSrcEn   = wrEn && (wrAddr == ADDR_SRC_EN);
    stb.wrGrpFlag = wrEn && (wrAddr == ADDR_GRP_FLAG);
    stb.wrGrpEn   = wrEn && (wrAddr == ADDR_GRP_EN);
    stb.wrCtl     = wrEn && (wrAddr == ADDR_CTL);
    stb.service   = ackIn && irqReq;
  end
endmodule

// File: rtl/mfi_datapath.sv
module mfi_datapath
  import mfi_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_GRP = 4,
  parameter int DW = 8,
  parameter int GW = 2,
  parameter logic [NUM_SRC*MAP_W-1:0] GRP_MAP = 24'h6D2240
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcSet,
  input  logic [DW-1:0]      wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  mfiStrobe_t         stb,
  input  logic [GW-1:0]      svcGrp,
  output logic [DW-1:0]      rdData,
  output logic [NUM_GRP-1:0] grpFlag,
  output logic [NUM_GRP-1:0] grpEn,
  output logic               globalEn
);
  logic [NUM_SRC-1:0] srcFlag;
  logic [NUM_SRC-1:0] srcEn;
  logic [NUM_SRC-1:0] srcRise;
  logic [NUM_SRC-1:0] srcKeep;
  logic [NUM_GRP-1:0] grpHit;
  logic [NUM_GRP-1:0] grpClr;
  logic [NUM_GRP-1:0] svcMask;

  function automatic logic [NUM_SRC-1:0] membersOf(input int g);
    logic [NUM_SRC-1:0] m;
    m = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (int'(GRP_MAP[s*MAP_W +: MAP_W]) == g) m[s] = 1'b1;
    end
    return m;
  endfunction

  // a rising event is a strobe on a source whose flag is still clear
  assign srcRise = srcSet & ~srcFlag;

  for (genvar g = 0; g < NUM_GRP; g++) begin : gGroup
    localparam logic [NUM_SRC-1:0] MEMBERS = membersOf(g);
    assign grpHit[g] = |(srcRise & srcEn & MEMBERS);
  end

  assign srcKeep = stb.wrSrcFlag ? wrData[NUM_SRC-1:0] : '1;
  assign svcMask = stb.service ? (NUM_GRP'(1) << svcGrp) : '0;
  assign grpClr  = (stb.wrGrpFlag ? ~wrData[NUM_GRP-1:0] : '0) | svcMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcFlag  <= '0;
      srcEn    <= '0;
      grpFlag  <= '0;
      grpEn    <= '0;
      globalEn <= 1'b0;
    end else begin
      srcFlag <= srcSet | (srcFlag & srcKeep);
      grpFlag <= grpHit | (grpFlag & ~grpClr);
      if (stb.wrSrcEn) srcEn <= wrData[NUM_SRC-1:0];
      if (stb.wrGrpEn) grpEn <= wrData[NUM_GRP-1:0];
      if (stb.service)    globalEn <= 1'b0;
      else if (stb.wrCtl) globalEn <= wrData[0];
    end
  end

  always_comb begin
    case (rdAddr)
      ADDR_SRC_FLAG: rdData = DW'(srcFlag);
      ADDR_SRC_EN:   rdData = DW'(srcEn);
      ADDR_GRP_FLAG: rdData = DW'(grpFlag);
      ADDR_GRP_EN:   rdData = DW'(grpEn);
      ADDR_CTL:      rdData = DW'(globalEn);
      default:       rdData = '0;
    endcase
  end
endmodule

// File: rtl/mfi_aggregator.sv
module mfi_aggregator
  import mfi_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_GRP = 4,
  parameter int DW = 8,
  parameter logic [NUM_SRC*MAP_W-1:0] GRP_MAP = 24'h6D2240,
  localparam int GW = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcSet,
  input  logic               stackNotFull,
  input  logic               ackIn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DW-1:0]      wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DW-1:0]      rdData,
  output logic               irqReq,
  output logic [GW-1:0]      irqGrp
);
  mfiStrobe_t stb;
  logic [GW-1:0] svcGrp;
  logic [NUM_GRP-1:0] grpFlag;
  logic [NUM_GRP-1:0] grpEn;
  logic globalEn;

  mfi_ctrl #(.NUM_GRP(NUM_GRP), .GW(GW)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .grpFlag(grpFlag), .grpEn(grpEn),
    .globalEn(globalEn), .stackNotFull(stackNotFull), .ackIn(ackIn),
    .stb(stb), .svcGrp(svcGrp), .irqReq(irqReq), .irqGrp(irqGrp)
  );

  mfi_datapath #(
    .NUM_SRC(NUM_SRC), .NUM_GRP(NUM_GRP), .DW(DW), .GW(GW), .GRP_MAP(GRP_MAP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .srcSet(srcSet), .wrData(wrData), .rdAddr(rdAddr),
    .stb(stb), .svcGrp(svcGrp), .rdData(rdData), .grpFlag(grpFlag),
    .grpEn(grpEn), .globalEn(globalEn)
  );
endmodule

// File: rtl/mfi_checker.sv
module mfi_checker
  import mfi_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_GRP = 4,
  parameter int GW = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcSet,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic               ackIn,
  input logic               stackNotFull,
  input logic               irqReq,
  input logic [GW-1:0]      irqGrp,
  input logic [NUM_GRP-1:0] grpFlag,
  input logic [NUM_GRP-1:0] grpEn,
  input logic               globalEn
);
  p_req_gating_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (stackNotFull && globalEn));

  p_grp_pending_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (grpFlag[irqGrp] && grpEn[irqGrp]));

  p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ((grpFlag & grpEn & ((NUM_GRP'(1) << irqGrp) - NUM_GRP'(1))) == '0));

  p_service_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && irqReq && (srcSet == '0)) |=> (!globalEn && !grpFlag[$past(irqGrp)]));

  p_group_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((grpFlag & ~$past(grpFlag)) != '0) |-> ($past(srcSet) != '0));

  p_global_by_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(globalEn) |-> $past(wrEn && (wrAddr == ADDR_CTL)));
endmodule

bind mfi_aggregator mfi_checker #(.NUM_SRC(NUM_SRC), .NUM_GRP(NUM_GRP), .GW(GW)) u_chk (
  .clk(clk), .rstN(rstN), .srcSet(srcSet), .wrEn(wrEn), .wrAddr(wrAddr),
  .ackIn(ackIn), .stackNotFull(stackNotFull), .irqReq(irqReq), .irqGrp(irqGrp),
  .grpFlag(grpFlag), .grpEn(grpEn), .globalEn(globalEn)
);

// File: tb/sim_mfi_aggregator.sv
module sim_mfi_aggregator;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] srcSet = '0;
  logic stackNotFull = 1'b1;
  logic ackIn = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic irqReq;
  logic [1:0] irqGrp;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [2:0] addr;
    logic [7:0] expData;
    logic expReq;
    logic [1:0] expGrp;
    string tag;
  } item_t;

  item_t q[$];
  event probeEv;

  always #10 clk = ~clk;

  mfi_aggregator u0 (
    .clk(clk), .rstN(rstN), .srcSet(srcSet), .stackNotFull(stackNotFull),
    .ackIn(ackIn), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irqReq(irqReq), .irqGrp(irqGrp)
  );

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(probeEv);
      #1;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        total++;
        if (rdData !== it.expData || irqReq !== it.expReq ||
            (it.expReq && irqGrp !== it.expGrp)) begin
          bad++;
          $display("FAIL %s: addr=%0d data=%02h/%02h req=%0b/%0b grp=%0d/%0d (actual/expected)",
                   it.tag, it.addr, rdData, it.expData, irqReq, it.expReq, irqGrp, it.expGrp);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic probe(input logic [2:0] a, input logic [7:0] d, input logic r,
                       input logic [1:0] g, input string tag);
    item_t it;
    rdAddr = a;
    it.addr = a; it.expData = d; it.expReq = r; it.expGrp = g; it.tag = tag;
    q.push_back(it);
    ->probeEv;
    #3;
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m);
    srcSet = m;
    tick();
    srcSet = '0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    for (int a = 0; a < 5; a++) probe(3'(a), 8'h00, 1'b0, 2'd0, "R1 reset");

    regWrite(3'd3, 8'h0F);
    regWrite(3'd4, 8'h01);
    regWrite(3'd1, 8'hFD);
    probe(3'd1, 8'hFD, 1'b0, 2'd0, "R10 source enable readback");
    probe(3'd3, 8'h0F, 1'b0, 2'd0, "R10 group enable readback");

    // disabled source 1 (group 0)
    pulse(8'h02);
    probe(3'd0, 8'h02, 1'b0, 2'd0, "R2 flag set while disabled");
    probe(3'd2, 8'h00, 1'b0, 2'd0, "R4 disabled member no group");

    // source 5 -> group 2
    pulse(8'h20);
    probe(3'd2, 8'h04, 1'b1, 2'd2, "R3 group 2 set");
    probe(3'd4, 8'h01, 1'b1, 2'd2, "R6 request raised");

    pulse(8'h40);
    probe(3'd2, 8'h0C, 1'b1, 2'd2, "R7 group 2 beats 3");
    pulse(8'h08);
    probe(3'd2, 8'h0E, 1'b1, 2'd1, "R7 group 1 wins");

    stackNotFull = 1'b0;
    probe(3'd2, 8'h0E, 1'b0, 2'd0, "R6 stack full blocks");
    stackNotFull = 1'b1;

    // service group 1
    ackIn = 1'b1;
    tick();
    ackIn = 1'b0;
    probe(3'd2, 8'h0C, 1'b0, 2'd0, "R8 group flag cleared");
    probe(3'd4, 8'h00, 1'b0, 2'd0, "R8 global enable cleared");
    probe(3'd0, 8'h6A, 1'b0, 2'd0, "R8 source flags kept");

    // acknowledge with no request
    ackIn = 1'b1;
    tick();
    ackIn = 1'b0;
    probe(3'd2, 8'h0C, 1'b0, 2'd0, "R10 idle ack ignored");

    regWrite(3'd2, 8'h0B);
    probe(3'd2, 8'h08, 1'b0, 2'd0, "R9 group write-zero clear");

    pulse(8'h20);
    probe(3'd2, 8'h08, 1'b0, 2'd0, "R5 already-set source no group");

    regWrite(3'd0, 8'hDF);
    probe(3'd0, 8'h4A, 1'b0, 2'd0, "R9 source write-zero clear");
    pulse(8'h20);
    probe(3'd2, 8'h0C, 1'b0, 2'd0, "R3 re-rise sets group 2");

    // clear all sources while source 0 strobes
    srcSet = 8'h01; wrEn = 1'b1; wrAddr = 3'd0; wrData = 8'h00;
    tick();
    srcSet = '0; wrEn = 1'b0;
    probe(3'd0, 8'h01, 1'b0, 2'd0, "R9 set wins over clear");
    probe(3'd2, 8'h0D, 1'b0, 2'd0, "R3 group 0 set");

    regWrite(3'd4, 8'h01);
    probe(3'd4, 8'h01, 1'b1, 2'd0, "R7 lowest group 0");

    regWrite(3'd3, 8'h0C);
    probe(3'd3, 8'h0C, 1'b1, 2'd2, "R6 group enable masks group 0");

    tick();
    done = 1;
    summary();
  end
endmodule